// File: doc/BRIEF.md
# Stereo Disparity Strip Sequencer

This block lets a disparity correlator with short line buffers work on a frame wider than those buffers. The frame is cut into vertical strips that overlap. Each strip is twice the disparity search range D wide, and successive strips begin D columns apart. The strips are run one after another. For each strip the sequencer scans every row from top to bottom. Within each row it issues one frame-buffer read per strip column, in ascending order, to the correlator over a valid/ready channel. Read columns that fall outside the image are flagged so the correlator feeds zeros for them.

Correlator results come back in the same order as the reads. A second walker follows them, and the sequencer maps each result onto the continuous output disparity image. The left half of each strip is only there to give the correlator its search context, so those results are dropped. The right half, D columns, is written at `row*width + column`. Together the strips tile the output with no gap and no column written twice. Width and D are sampled when a run is accepted. A one-cycle done pulse marks the last retired result. The vertical margin that the 5x5 matching window needs is left to the correlator and the frame-buffer layout.

Top module: `strip_seq_top`

## Requirements
- R1: During and right after reset, `busy`, `done`, `rd_valid` and `wr_valid` are all 0.
- R2: Reads run strip by strip, then row by row (0 to ROWS-1), then local column 0 to 2D-1. Local column c of strip i stands for image column i*D - D + c. When that column lies inside the image, the address is row*width + column.
- R3: A read whose image column is below 0 or at or above the width has `rd_pad` = 1 and `rd_addr` = 0. Any other read has `rd_pad` = 0.
- R4: A run issues exactly ceil(width/D) strips. The last strip is the first one whose base column i*D plus D reaches the width.
- R5: A result produces a write (`wr_valid` = 1 in the same cycle as `res_valid`) only when its local column is at least D and its image column is below the width. The write has `wr_addr` = row*width + column and `wr_data` = `res_data`.
- R6: Over one run, every output pixel (row below ROWS, column below width) is written exactly once.
- R7: `done` is high for exactly one cycle, in the cycle after the last result of the last strip is accepted, and `busy` is 0 from that cycle on.
- R8: A `start` while `busy` is high is ignored. Changes to `cfg_width` and `cfg_disp` during a run have no effect on it.
- R9: While `rd_valid` is high and `rd_ready` is low, the read request holds: `rd_valid`, `rd_addr` and `rd_pad` do not change.
- R10: A `start` with `cfg_width` = 0 or `cfg_disp` = 0 is ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a run with the present configuration |
| cfg_width | input | COL_W | Image width in columns |
| cfg_disp | input | COL_W | Disparity search range D |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last result is retired |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Correlator accepts the read request |
| rd_addr | output | ADDR_W | Frame-buffer pixel address, 0 when padded |
| rd_pad | output | 1 | Column is outside the image; correlator should use zero |
| res_valid | input | 1 | Correlator result valid, in read order |
| res_data | input | DATA_W | Correlator disparity value |
| wr_valid | output | 1 | Write this result to the output image |
| wr_addr | output | ADDR_W | Output image pixel address |
| wr_data | output | DATA_W | Disparity value to write |

## Verification
The bench goes after the two image edges. At the left edge the first strip's leading half must be padded; a design that forgets this reads wrapped or negative addresses. At the right edge a width that is not a multiple of D leaves a partial last strip; a wrong end test would drop that strip, or run one strip too many and write past the row. Output coverage is counted per pixel, so an off-by-one in the stitching shows up as a missing or doubled column. Stalls on both channels check that the request holds under backpressure and that the result walker stays in step with the read walker. Mid-run start pulses with altered configuration expose a design that reloads or re-latches while busy.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/strip_walker.sv
// Walks strip / row / local column in issue order; tracks the strip base
// column and the row start address incrementally so no multiplier is needed.
module strip_walker #(
    parameter int COL_W  = 11,
    parameter int ROW_W  = 9,
    parameter int ADDR_W = 20,
    parameter int ROWS   = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [COL_W-1:0]  width,
    input  logic [COL_W-1:0]  disp,
    output logic [COL_W:0]    lcol,
    output logic [COL_W:0]    base,
    output logic [ADDR_W-1:0] row_off,
    output logic              last
);
    typedef struct packed {
        logic [COL_W:0]    lcol;
        logic [COL_W:0]    base;
        logic [ROW_W-1:0]  row;
        logic [ADDR_W-1:0] row_off;
    } walk_t;

    walk_t w_d, w_q;
    logic  lcol_end_d, row_end_d, strip_end_d;
    logic [COL_W+1:0] reach_d;
    logic [COL_W:0]   span_d;

    always_comb begin
        span_d      = {disp, 1'b0};
        lcol_end_d  = (w_q.lcol == span_d - 1'b1);
        row_end_d   = (w_q.row == ROW_W'(ROWS - 1));
        reach_d     = {1'b0, w_q.base} + {2'b0, disp};
        strip_end_d = (reach_d >= {2'b0, width});
        last        = lcol_end_d && row_end_d && strip_end_d;

        w_d = w_q;
        if (load) begin
            w_d = '0;
        end else if (step) begin
            if (!lcol_end_d) begin
                w_d.lcol = w_q.lcol + 1'b1;
            end else begin
                w_d.lcol = '0;
                if (!row_end_d) begin
                    w_d.row     = w_q.row + 1'b1;
                    w_d.row_off = w_q.row_off + ADDR_W'(width);
                end else begin
                    w_d.row     = '0;
                    w_d.row_off = '0;
                    w_d.base    = w_q.base + {1'b0, disp};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign lcol    = w_q.lcol;
    assign base    = w_q.base;
    assign row_off = w_q.row_off;
endmodule

// File: rtl/col_mapper.sv
// Maps a walker position onto an image address. IS_WRITE selects the flag:
// read side reports "inside image", write side reports "kept output column".
module col_mapper #(
    parameter int COL_W    = 11,
    parameter int ADDR_W   = 20,
    parameter bit IS_WRITE = 1'b0
) (
    input  logic [COL_W:0]    lcol,
    input  logic [COL_W:0]    base,
    input  logic [ADDR_W-1:0] row_off,
    input  logic [COL_W-1:0]  width,
    input  logic [COL_W-1:0]  disp,
    output logic              hit,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = COL_W + 2;

    logic [EXT_W-1:0] u_d, d_ext_d, w_ext_d, col_d;
    logic             outside_d;

    always_comb begin
        u_d       = {1'b0, base} + {1'b0, lcol};
        d_ext_d   = {2'b0, disp};
        w_ext_d   = {2'b0, width};
        col_d     = u_d - d_ext_d;
        outside_d = (u_d < d_ext_d) || (u_d >= w_ext_d + d_ext_d);
        addr      = outside_d ? '0 : row_off + ADDR_W'(col_d);
    end

    generate
        if (IS_WRITE) begin : g_keep
            assign hit = ({1'b0, lcol} >= {1'b0, d_ext_d[COL_W:0]}) && !outside_d;
        end else begin : g_inside
            assign hit = !outside_d;
        end
    endgenerate
endmodule

// File: rtl/strip_seq_top.sv
module strip_seq_top
    import strip_seq_pkg::*;
#(
    parameter int MAX_WIDTH = 1280,
    parameter int ROWS      = 480,
    parameter int DATA_W    = 8,
    localparam int COL_W    = $clog2(MAX_WIDTH + 1),
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int ADDR_W   = $clog2(MAX_WIDTH * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  cfg_width,
    input  logic [COL_W-1:0]  cfg_disp,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_pad,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        seq_state_e       state;
        logic [COL_W-1:0] width;
        logic [COL_W-1:0] disp;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic load_d;
    logic [1:0]        step_v, last_v, hit_v;
    logic [COL_W:0]    lcol_v    [2];
    logic [COL_W:0]    base_v    [2];
    logic [ADDR_W-1:0] row_off_v [2];
    logic [ADDR_W-1:0] addr_v    [2];
    logic [COL_W-1:0]  width_q, disp_q;

    assign width_q  = c_q.width;
    assign disp_q   = c_q.disp;
    assign busy     = (c_q.state != SQ_IDLE);
    assign done     = c_q.done;
    assign rd_valid = (c_q.state == SQ_ISSUE);
    assign step_v[0] = rd_valid && rd_ready;
    assign step_v[1] = res_valid && busy;

    // lane 0 walks issued reads, lane 1 walks retired results
    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            strip_walker #(
                .COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .ROWS(ROWS)
            ) u_walk (
                .clk(clk), .rst_n(rst_n), .load(load_d), .step(step_v[g]),
                .width(width_q), .disp(disp_q),
                .lcol(lcol_v[g]), .base(base_v[g]), .row_off(row_off_v[g]),
                .last(last_v[g])
            );
            col_mapper #(
                .COL_W(COL_W), .ADDR_W(ADDR_W), .IS_WRITE(g == 1)
            ) u_map (
                .lcol(lcol_v[g]), .base(base_v[g]), .row_off(row_off_v[g]),
                .width(width_q), .disp(disp_q),
                .hit(hit_v[g]), .addr(addr_v[g])
            );
        end
    endgenerate

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load_d   = 1'b0;
        unique case (c_q.state)
            SQ_IDLE: begin
                if (start && (cfg_width != '0) && (cfg_disp != '0)) begin
                    c_d.state = SQ_ISSUE;
                    c_d.width = cfg_width;
                    c_d.disp  = cfg_disp;
                    load_d    = 1'b1;
                end
            end
            SQ_ISSUE: begin
                if (step_v[0] && last_v[0]) c_d.state = SQ_DRAIN;
            end
            default: ;
        endcase
        if (step_v[1] && last_v[1]) begin
            c_d.state = SQ_IDLE;
            c_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: SQ_IDLE, width: '0, disp: '0, done: 1'b0};
        else        c_q <= c_d;
    end

    assign rd_addr  = addr_v[0];
    assign rd_pad   = !hit_v[0];
    assign wr_valid = step_v[1] && hit_v[1];
    assign wr_addr  = addr_v[1];
    assign wr_data  = res_data;
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
    parameter int COL_W  = 11,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [COL_W-1:0]  cfg_width,
    input logic [COL_W-1:0]  cfg_disp,
    input logic              busy,
    input logic              done,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_pad,
    input logic              res_valid,
    input logic              wr_valid,
    input logic [COL_W-1:0]  width_q,
    input logic [COL_W-1:0]  disp_q
);
    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_pad |-> rd_addr == '0);

    assert_write_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> res_valid && busy);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(width_q) && $stable(disp_q));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_pad));

    assert_zero_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && (cfg_width == '0 || cfg_disp == '0) |=> !busy);
endmodule

bind strip_seq_top strip_seq_chk #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
    .cfg_disp(cfg_disp), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_pad(rd_pad),
    .res_valid(res_valid), .wr_valid(wr_valid), .width_q(width_q),
    .disp_q(disp_q)
);

// File: tb/tb_strip_seq_top.sv
module tb_strip_seq_top;
    localparam int MAXW   = 64;
    localparam int NROWS  = 3;
    localparam int COL_W  = $clog2(MAXW + 1);
    localparam int ADDR_W = $clog2(MAXW * NROWS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [COL_W-1:0] cfg_width = '0, cfg_disp = '0;
    logic busy, done, rd_valid, rd_pad, wr_valid;
    logic rd_ready = 1'b0, res_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] res_data = '0, wr_data;

    int checks = 0;
    int failures = 0;
    logic [7:0] fifo [0:1023];
    int cov [0:MAXW*NROWS-1];

    always #5 clk = ~clk;

    strip_seq_top #(.MAX_WIDTH(MAXW), .ROWS(NROWS), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
        .cfg_disp(cfg_disp), .busy(busy), .done(done), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_pad(rd_pad),
        .res_valid(res_valid), .res_data(res_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        check(busy == 0 && done == 0, "R1 busy/done in reset", {busy, done}, 0);
        check(rd_valid == 0 && wr_valid == 0, "R1 valids in reset", {rd_valid, wr_valid}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check(busy == 0 && done == 0 && rd_valid == 0, "R1 after reset", {busy, done, rd_valid}, 0);
    endtask

    task automatic test_zero_cfg(input int w, input int d);
        @(negedge clk); cfg_width = COL_W'(w); cfg_disp = COL_W'(d); start = 1'b1;
        @(negedge clk); start = 1'b0; #1;
        check(busy == 0 && rd_valid == 0, "R10 zero config ignored", busy, 0);
    endtask

    // One full frame: models the correlator stub and checks reads and writes.
    task automatic run_frame(input int w, input int d, input int mode, input bit inject);
        int es = 0, er = 0, ec = 0;
        int rs = 0, rr = 0, rc = 0;
        int head = 0, tail = 0, nreads = 0, ncyc = 0;
        int ns = (w + d - 1) / d;
        int bad_rd = 0, bad_wr = 0, bad_cov = 0;
        bit stall = 0, finished = 0;
        logic [ADDR_W-1:0] stall_addr = '0;
        for (int i = 0; i < MAXW * NROWS; i++) cov[i] = 0;

        @(negedge clk); cfg_width = COL_W'(w); cfg_disp = COL_W'(d); start = 1'b1;
        @(negedge clk); start = 1'b0; #1;
        check(busy == 1, "R2 run accepted", busy, 1);

        while (!finished && ncyc < 20000) begin
            @(negedge clk);
            rd_ready  = (mode == 0) ? 1'b1 : ((ncyc % 3) != 0);
            res_valid = (head != tail) && (mode == 0 || (ncyc % 2) == 0);
            res_data  = fifo[head % 1024];
            start     = inject && (ncyc == 7 || ncyc == 40);
            if (start) begin cfg_width = COL_W'(w + 3); cfg_disp = 1; end
            else if (inject) begin cfg_width = COL_W'(w); cfg_disp = COL_W'(d); end
            #1;
            if (stall) begin
                if (!(rd_valid && rd_addr == stall_addr)) begin
                    bad_rd++;
                    $display("FAIL R9 stalled request changed actual=%0d expected=%0d", rd_addr, stall_addr);
                end
            end
            stall = rd_valid && !rd_ready;
            stall_addr = rd_addr;

            if (rd_valid && rd_ready) begin
                int col = es * d - d + ec;
                bit epad = (col < 0) || (col >= w);
                int eaddr = epad ? 0 : er * w + col;
                if (rd_pad !== epad || rd_addr !== ADDR_W'(eaddr)) begin
                    bad_rd++;
                    $display("FAIL R2/R3 read %0d actual=%0d/%0d expected=%0d/%0d",
                             nreads, rd_pad, rd_addr, epad, eaddr);
                end
                fifo[tail % 1024] = rd_pad ? 8'hEE : rd_addr[7:0];
                tail++; nreads++;
                ec++;
                if (ec == 2 * d) begin ec = 0; er++; if (er == NROWS) begin er = 0; es++; end end
            end

            if (res_valid) begin
                int col = rs * d - d + rc;
                bit ekeep = (rc >= d) && (col < w);
                if (wr_valid !== ekeep) begin
                    bad_wr++;
                    $display("FAIL R5 keep actual=%0d expected=%0d", wr_valid, ekeep);
                end else if (ekeep) begin
                    if (wr_addr !== ADDR_W'(rr * w + col) || wr_data !== res_data) begin
                        bad_wr++;
                        $display("FAIL R5 write actual=%0d expected=%0d", wr_addr, rr * w + col);
                    end
                    if (int'(wr_addr) < MAXW * NROWS) cov[wr_addr]++;
                end
                head++;
                rc++;
                if (rc == 2 * d) begin rc = 0; rr++; if (rr == NROWS) begin rr = 0; rs++; end end
            end else if (wr_valid) begin
                bad_wr++;
                $display("FAIL R5 write without result actual=1 expected=0");
            end

            if (done) begin
                finished = 1;
                check(busy == 0 && head == tail, "R7 idle and drained at done", busy, 0);
            end
            ncyc++;
        end
        start = 1'b0; res_valid = 1'b0; rd_ready = 1'b0;
        check(finished, "R7 done pulse seen", finished, 1);
        @(negedge clk); #1;
        check(done == 0, "R7 done lasts one cycle", done, 0);
        check(bad_rd == 0, "R2 read sequence", bad_rd, 0);
        check(bad_wr == 0, "R5 writes", bad_wr, 0);
        check(es == ns && nreads == ns * NROWS * 2 * d, "R4 strip count", nreads, ns * NROWS * 2 * d);
        for (int i = 0; i < w * NROWS; i++) if (cov[i] != 1) bad_cov++;
        check(bad_cov == 0, "R6 each pixel written once", bad_cov, 0);
        if (inject) check(bad_rd == 0 && es == ns, "R8 busy start ignored", es, ns);
        check(mode == 0 || bad_rd == 0, "R9 backpressure run", bad_rd, 0);
        check(bad_rd == 0, "R3 edge padding", bad_rd, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset();
        run_frame(20, 2, 0, 1'b0);
        run_frame(10, 3, 1, 1'b0);
        run_frame(5, 5, 0, 1'b0);
        run_frame(7, 8, 1, 1'b0);
        run_frame(40, 4, 1, 1'b1);
        test_zero_cfg(10, 0);
        test_zero_cfg(0, 4);
        run_frame(11, 1, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule